// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block tracks the privilege state of a processing core across trap entry and trap return. It holds the current privilege level (0 to 3), the register width mode (64-bit or 32-bit), the stack-pointer choice (shared level-0 stack or the level's own stack), an illegal-state bit, a small condition-flag field, and the security state seen by the levels below the top one. A level-0 context is never entered by a trap. Each of levels 1 to 3 has a saved-status slot and a saved-return-address slot. A trap aimed at a level fills that level's pair. A trap return executed at a level reads that level's pair back.

An accepted trap produces a one-cycle `pc_load` pulse with the handler address. That address is the target level's vector base plus a group offset and a per-type offset. The group offset depends on where the trap came from. A trap return also produces a `pc_load` pulse, carrying the saved return address. The return is checked for legality against the level and width rules and against the configured widths. A legal return restores the whole state in one cycle. An illegal return leaves level, width, stack choice and flags alone and raises the illegal-state bit.

The control is a state machine whose state is the current level, with the states LV0, LV1, LV2 and LV3. The reset state is LV3. Each cycle one operation is chosen:

- OP_ENTER: an accepted trap moves to the target level.
- OP_RET_OK: a legal return moves to the saved level.
- OP_RET_BAD: an illegal return keeps the level.
- OP_SPSEL: a stack-select write keeps the level.
- OP_IDLE: nothing happens and the level is held.

All outputs are registered. They change one clock edge after the request.

Top module: `exc_ctrl`

## Requirements
- R1: After reset the outputs are: level 3, 64-bit width, own stack selected, illegal bit 0, flags 0, secure 1, and `pc_load` 0.
- R2: A trap is accepted when its target level is 1 to 3, is implemented, and is not below the current level. One cycle after an accepted trap:
  - the level equals the target;
  - the own stack is selected;
  - the illegal bit and the flags are 0;
  - `pc_load` pulses once.
  A trap to level 0, or to a level below the current one, changes nothing and gives no `pc_load`.
- R3: The handler address is the target level's vector base plus a group offset plus 0x80 times the trap type. The group offsets are:
  - 0x000 when the source is the same level using the shared stack;
  - 0x200 when the source is the same level using its own stack;
  - 0x400 when the source is a lower level in 64-bit width;
  - 0x600 when the source is a lower level in 32-bit width.
- R4: An accepted trap stores the interrupted state in the target level's saved-status slot. The stored state is the flags from `ent_flags`, the width, the stack choice and the level. It also stores `ent_ret_addr` in that level's return-address slot. Both slots are read back only by a later return executed at that level.
- R5: The width after an accepted trap is the target's configured width OR the previous width. The configured width is `cfg_l1_w64` for level 1, `cfg_l2_w64` for level 2, and always 64-bit for level 3. Moving up therefore never drops from 64-bit to 32-bit.
- R6: A return executed at level L (L of 1 or more) pulses `pc_load` with the return address saved for L. If the return is legal, level, width, stack choice and flags are all restored in that same cycle from L's saved status, and the illegal bit is cleared.
- R7: A return is illegal in any of these cases:
  - the saved level is above L, or is not implemented;
  - the saved level equals L and the saved width differs from the current width;
  - the saved level is below L, the saved width is 64-bit and the current width is 32-bit;
  - the saved width disagrees with the configuration. This applies when the saved level is 1 and the width differs from `cfg_l1_w64`, when it is 2 and differs from `cfg_l2_w64`, when it is 3 and is not 64-bit, or when it is 0 and is 64-bit while `cfg_l1_w64` is 0.
  An illegal return keeps level, width, stack choice and flags, and sets the illegal bit.
- R8: A return requested at level 0 is ignored: there is no `pc_load` and no state change.
- R9: `cur_secure` is 1 whenever the level is 3. Below level 3 it shows a latched value. That value is reset to 1 and is loaded with the inverse of `cfg_lower_nsec` only by a legal return from level 3 to a lower level.
- R10: When a trap is accepted in the same cycle as a return request, only the trap takes effect. The return is dropped, and the saved slots it would have read are left intact.
- R11: `sp_sel_we` sets the stack choice to `sp_sel_val` at levels 1 to 3, but only when no trap is accepted and no return is performed in that cycle. It is ignored at level 0 and never pulses `pc_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_req | input | 1 | Trap request |
| ent_type | input | TW | Trap type index |
| ent_lvl | input | 2 | Trap target level |
| ent_ret_addr | input | AW | Return address of the interrupted context |
| ent_flags | input | FLAG_W | Condition flags of the interrupted context |
| ret_req | input | 1 | Trap-return request |
| sp_sel_we | input | 1 | Stack-select write |
| sp_sel_val | input | 1 | Stack choice to write (1 = own stack) |
| cfg_l1_w64 | input | 1 | Configured width for level 1 (1 = 64-bit) |
| cfg_l2_w64 | input | 1 | Configured width for level 2 (1 = 64-bit) |
| cfg_lower_nsec | input | 1 | Requested non-secure state for levels below 3 |
| vec_base1 | input | AW | Vector base of level 1 |
| vec_base2 | input | AW | Vector base of level 2 |
| vec_base3 | input | AW | Vector base of level 3 |
| cur_lvl | output | 2 | Current level |
| cur_w64 | output | 1 | Current width (1 = 64-bit) |
| cur_stk_own | output | 1 | Own stack selected |
| cur_il | output | 1 | Illegal-state bit |
| cur_secure | output | 1 | Current security state (1 = secure) |
| cur_flags | output | FLAG_W | Current condition flags |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_target | output | AW | Program counter value to load |

## Verification
A trap and a trap return can be requested in the same cycle. The same is true of a stack-select write together with either of them. The bench provokes these collisions on purpose by drawing all three requests independently in every cycle of a long pseudo-random sweep. The expected result of each collision is computed from the priority order: an accepted trap first, then a return, then a stack-select write. The bench judges the outcome both at once and later. It checks that cycle's level and `pc_target`. It also checks the state restored by any return issued afterwards, which proves that a return dropped in a collision did not consume or disturb its saved slots.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int unsigned FLAG_W     = 4;
    localparam int unsigned GRP_SHIFT  = 9;
    localparam int unsigned TYPE_SHIFT = 7;

    typedef enum logic [1:0] {
        LV0 = 2'd0,
        LV1 = 2'd1,
        LV2 = 2'd2,
        LV3 = 2'd3
    } lvl_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ENTER,
        OP_RET_OK,
        OP_RET_BAD,
        OP_SPSEL
    } op_t;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              w64;
        logic              stk_own;
        lvl_t              lvl;
    } sts_t;

endpackage

// File: rtl/exc_bank.sv
module exc_bank
    import exc_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  lvl_t          wr_lvl,
    input  sts_t          wr_sts,
    input  logic [AW-1:0] wr_addr,
    input  lvl_t          rd_lvl,
    output sts_t          rd_sts,
    output logic [AW-1:0] rd_addr
);

    localparam int unsigned NLVL = 1 << $bits(lvl_t);

    sts_t          sts_q [NLVL];
    logic [AW-1:0] adr_q [NLVL];

    // one saved-status and one return-address slot per level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLVL; i++) begin
                sts_q[i] <= '0;
                adr_q[i] <= '0;
            end
        end else if (wr_en) begin
            sts_q[wr_lvl] <= wr_sts;
            adr_q[wr_lvl] <= wr_addr;
        end
    end

    assign rd_sts  = sts_q[rd_lvl];
    assign rd_addr = adr_q[rd_lvl];

endmodule

// File: rtl/exc_vec.sv
module exc_vec
    import exc_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned TW = 2
) (
    input  lvl_t          tgt,
    input  lvl_t          src,
    input  logic          src_w64,
    input  logic          src_own,
    input  logic [TW-1:0] etype,
    input  logic [AW-1:0] base1,
    input  logic [AW-1:0] base2,
    input  logic [AW-1:0] base3,
    output logic [AW-1:0] handler
);

    logic [1:0]    grp;
    logic [AW-1:0] base;
    logic [AW-1:0] off;

    always_comb begin
        case (tgt)
            LV1:     base = base1;
            LV2:     base = base2;
            LV3:     base = base3;
            default: base = '0;
        endcase
        // group: same level (shared / own stack) or lower level (64 / 32)
        if (src < tgt) grp = src_w64 ? 2'd2 : 2'd3;
        else           grp = src_own ? 2'd1 : 2'd0;
        off     = (AW'(grp) << GRP_SHIFT) | (AW'(etype) << TYPE_SHIFT);
        handler = base + off;
    end

endmodule

// File: rtl/exc_ret_chk.sv
module exc_ret_chk
    import exc_pkg::*;
#(
    parameter bit HAS_L2 = 1'b1,
    parameter bit HAS_L3 = 1'b1,
    parameter bit L3_W64 = 1'b1
) (
    input  lvl_t cur_lvl,
    input  logic cur_w64,
    input  lvl_t sv_lvl,
    input  logic sv_w64,
    input  logic cfg_l1_w64,
    input  logic cfg_l2_w64,
    output logic legal
);

    localparam logic [3:0] IMPL = {HAS_L3, HAS_L2, 2'b11};

    logic bad;

    always_comb begin
        bad = 1'b0;
        if (sv_lvl > cur_lvl)                          bad = 1'b1;
        if (!IMPL[sv_lvl])                             bad = 1'b1;
        if (sv_lvl == cur_lvl && sv_w64 != cur_w64)    bad = 1'b1;
        if (sv_lvl <  cur_lvl && sv_w64 && !cur_w64)   bad = 1'b1;
        case (sv_lvl)
            LV0:     if (sv_w64 && !cfg_l1_w64)        bad = 1'b1;
            LV1:     if (sv_w64 != cfg_l1_w64)         bad = 1'b1;
            LV2:     if (sv_w64 != cfg_l2_w64)         bad = 1'b1;
            default: if (sv_w64 != L3_W64)             bad = 1'b1;
        endcase
        legal = !bad;
    end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned TW     = 2,
    parameter bit          HAS_L2 = 1'b1,
    parameter bit          HAS_L3 = 1'b1,
    parameter bit          L3_W64 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_req,
    input  logic [TW-1:0]     ent_type,
    input  logic [1:0]        ent_lvl,
    input  logic [AW-1:0]     ent_ret_addr,
    input  logic [FLAG_W-1:0] ent_flags,
    input  logic              ret_req,
    input  logic              sp_sel_we,
    input  logic              sp_sel_val,
    input  logic              cfg_l1_w64,
    input  logic              cfg_l2_w64,
    input  logic              cfg_lower_nsec,
    input  logic [AW-1:0]     vec_base1,
    input  logic [AW-1:0]     vec_base2,
    input  logic [AW-1:0]     vec_base3,
    output logic [1:0]        cur_lvl,
    output logic              cur_w64,
    output logic              cur_stk_own,
    output logic              cur_il,
    output logic              cur_secure,
    output logic [FLAG_W-1:0] cur_flags,
    output logic              pc_load,
    output logic [AW-1:0]     pc_target
);

    localparam lvl_t       TOP_LVL = HAS_L3 ? LV3 : (HAS_L2 ? LV2 : LV1);
    localparam bit         RST_W64 = HAS_L3 ? L3_W64 : 1'b1;
    localparam logic [3:0] IMPL    = {HAS_L3, HAS_L2, 2'b11};

    lvl_t              lvl_q, lvl_d, ent_tgt;
    logic              w64_q, w64_d, own_q, own_d, il_q, il_d;
    logic [FLAG_W-1:0] fl_q, fl_d;
    logic              pcl_q, pcl_d;
    logic [AW-1:0]     pc_q, pc_d;
    logic              low_sec, leave_top;
    op_t               op;
    sts_t              wr_sts, rd_sts;
    logic [AW-1:0]     rd_addr, handler;
    logic              ret_legal, ent_ok, tgt_cfg_w64;

    assign ent_tgt = lvl_t'(ent_lvl);
    assign ent_ok  = ent_req && (ent_tgt != LV0) && IMPL[ent_tgt] && (ent_tgt >= lvl_q);

    always_comb begin
        case (ent_tgt)
            LV1:     tgt_cfg_w64 = cfg_l1_w64;
            LV2:     tgt_cfg_w64 = cfg_l2_w64;
            LV3:     tgt_cfg_w64 = L3_W64;
            default: tgt_cfg_w64 = 1'b0;
        endcase
    end

    // operation select: entry, then return, then stack-select write
    always_comb begin
        if (ent_ok)                           op = OP_ENTER;
        else if (ret_req && lvl_q != LV0)     op = ret_legal ? OP_RET_OK : OP_RET_BAD;
        else if (sp_sel_we && lvl_q != LV0)   op = OP_SPSEL;
        else                                  op = OP_IDLE;
    end

    always_comb begin
        wr_sts.flags   = ent_flags;
        wr_sts.w64     = w64_q;
        wr_sts.stk_own = own_q;
        wr_sts.lvl     = lvl_q;
    end

    exc_bank #(.AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op == OP_ENTER),
        .wr_lvl  (ent_tgt),
        .wr_sts  (wr_sts),
        .wr_addr (ent_ret_addr),
        .rd_lvl  (lvl_q),
        .rd_sts  (rd_sts),
        .rd_addr (rd_addr)
    );

    exc_vec #(.AW(AW), .TW(TW)) u_vec (
        .tgt     (ent_tgt),
        .src     (lvl_q),
        .src_w64 (w64_q),
        .src_own (own_q),
        .etype   (ent_type),
        .base1   (vec_base1),
        .base2   (vec_base2),
        .base3   (vec_base3),
        .handler (handler)
    );

    exc_ret_chk #(.HAS_L2(HAS_L2), .HAS_L3(HAS_L3), .L3_W64(L3_W64)) u_rchk (
        .cur_lvl    (lvl_q),
        .cur_w64    (w64_q),
        .sv_lvl     (rd_sts.lvl),
        .sv_w64     (rd_sts.w64),
        .cfg_l1_w64 (cfg_l1_w64),
        .cfg_l2_w64 (cfg_l2_w64),
        .legal      (ret_legal)
    );

    // next state and next outputs
    always_comb begin
        lvl_d = lvl_q;
        w64_d = w64_q;
        own_d = own_q;
        il_d  = il_q;
        fl_d  = fl_q;
        pcl_d = 1'b0;
        pc_d  = pc_q;
        unique case (op)
            OP_ENTER: begin
                lvl_d = ent_tgt;
                w64_d = tgt_cfg_w64 | w64_q;
                own_d = 1'b1;
                il_d  = 1'b0;
                fl_d  = '0;
                pcl_d = 1'b1;
                pc_d  = handler;
            end
            OP_RET_OK: begin
                lvl_d = rd_sts.lvl;
                w64_d = rd_sts.w64;
                own_d = rd_sts.stk_own;
                fl_d  = rd_sts.flags;
                il_d  = 1'b0;
                pcl_d = 1'b1;
                pc_d  = rd_addr;
            end
            OP_RET_BAD: begin
                il_d  = 1'b1;
                pcl_d = 1'b1;
                pc_d  = rd_addr;
            end
            OP_SPSEL: own_d = sp_sel_val;
            OP_IDLE:  ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= TOP_LVL;
        else        lvl_q <= lvl_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w64_q <= RST_W64;
            own_q <= 1'b1;
            il_q  <= 1'b0;
            fl_q  <= '0;
            pcl_q <= 1'b0;
            pc_q  <= '0;
        end else begin
            w64_q <= w64_d;
            own_q <= own_d;
            il_q  <= il_d;
            fl_q  <= fl_d;
            pcl_q <= pcl_d;
            pc_q  <= pc_d;
        end
    end

    assign leave_top = (op == OP_RET_OK) && (lvl_q == LV3) && (rd_sts.lvl != LV3);

    generate
        if (HAS_L3) begin : g_sec
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         low_sec <= 1'b1;
                else if (leave_top) low_sec <= !cfg_lower_nsec;
            end
        end else begin : g_nosec
            assign low_sec = 1'b0;
        end
    endgenerate

    assign cur_lvl     = lvl_q;
    assign cur_w64     = w64_q;
    assign cur_stk_own = own_q;
    assign cur_il      = il_q;
    assign cur_flags   = fl_q;
    assign cur_secure  = (lvl_q == LV3) || low_sec;
    assign pc_load     = pcl_q;
    assign pc_target   = pc_q;

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
    parameter bit HAS_L2 = 1'b1,
    parameter bit HAS_L3 = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ent_req,
    input logic [1:0] ent_lvl,
    input logic       ret_req,
    input logic       sp_sel_we,
    input logic [1:0] cur_lvl,
    input logic       cur_w64,
    input logic       cur_stk_own,
    input logic       cur_il,
    input logic       cur_secure,
    input logic       pc_load
);

    logic tgt_impl;
    assign tgt_impl = (ent_lvl == 2'd1) || (ent_lvl == 2'd2 && HAS_L2) || (ent_lvl == 2'd3 && HAS_L3);

    // R2
    entry_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req && tgt_impl && ent_lvl >= cur_lvl
        |=> cur_lvl == $past(ent_lvl) && cur_stk_own && !cur_il && pc_load);

    // R2
    entry_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req && (ent_lvl == 2'd0 || ent_lvl < cur_lvl) && !ret_req && !sp_sel_we
        |=> !pc_load && cur_lvl == $past(cur_lvl));

    // R5
    up_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl > $past(cur_lvl)) && $past(cur_w64) |-> cur_w64);

    // R7
    down_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl < $past(cur_lvl)) && !$past(cur_w64) |-> !cur_w64);

    // R7
    bad_ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_il) |-> cur_lvl == $past(cur_lvl) && cur_w64 == $past(cur_w64));

    // R8
    l0_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req && cur_lvl == 2'd0 && !ent_req && !sp_sel_we |=> !pc_load && cur_lvl == 2'd0);

    // R9
    top_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lvl == 2'd3 |-> cur_secure);

    // R9
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lvl != 2'd3 && $past(cur_lvl) != 2'd3 |-> cur_secure == $past(cur_secure));

    // R6
    pc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(ent_req || ret_req));

endmodule

bind exc_ctrl exc_ctrl_chk #(.HAS_L2(HAS_L2), .HAS_L3(HAS_L3)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ent_req     (ent_req),
    .ent_lvl     (ent_lvl),
    .ret_req     (ret_req),
    .sp_sel_we   (sp_sel_we),
    .cur_lvl     (cur_lvl),
    .cur_w64     (cur_w64),
    .cur_stk_own (cur_stk_own),
    .cur_il      (cur_il),
    .cur_secure  (cur_secure),
    .pc_load     (pc_load)
);

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;

    localparam int AW = 32;
    localparam int TW = 2;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ent_req, ret_req, sp_sel_we, sp_sel_val;
    logic [TW-1:0] ent_type;
    logic [1:0]    ent_lvl;
    logic [AW-1:0] ent_ret_addr;
    logic [FW-1:0] ent_flags;
    logic          cfg_l1_w64, cfg_l2_w64, cfg_lower_nsec;
    logic [AW-1:0] vec_base1, vec_base2, vec_base3;
    logic [1:0]    cur_lvl;
    logic          cur_w64, cur_stk_own, cur_il, cur_secure, pc_load;
    logic [FW-1:0] cur_flags;
    logic [AW-1:0] pc_target;

    always #4 clk = ~clk;

    exc_ctrl #(.AW(AW), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .ent_req(ent_req), .ent_type(ent_type), .ent_lvl(ent_lvl),
        .ent_ret_addr(ent_ret_addr), .ent_flags(ent_flags), .ret_req(ret_req),
        .sp_sel_we(sp_sel_we), .sp_sel_val(sp_sel_val), .cfg_l1_w64(cfg_l1_w64),
        .cfg_l2_w64(cfg_l2_w64), .cfg_lower_nsec(cfg_lower_nsec), .vec_base1(vec_base1),
        .vec_base2(vec_base2), .vec_base3(vec_base3), .cur_lvl(cur_lvl), .cur_w64(cur_w64),
        .cur_stk_own(cur_stk_own), .cur_il(cur_il), .cur_secure(cur_secure),
        .cur_flags(cur_flags), .pc_load(pc_load), .pc_target(pc_target)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // bench model of the block state
    int            m_lvl;
    bit            m_w64, m_own, m_il, m_sec, e_pcl;
    logic [FW-1:0] m_fl;
    logic [AW-1:0] e_pc;
    int            s_lvl [4];
    bit            s_w64 [4];
    bit            s_own [4];
    logic [FW-1:0] s_fl  [4];
    logic [AW-1:0] s_ra  [4];
    logic [31:0]   rng;
    string         tag;

    task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    task automatic cmp_all(input string t);
        chk(t, "level", 32'(cur_lvl), 32'(m_lvl));
        chk(t, "width", 32'(cur_w64), 32'(m_w64));
        chk(t, "stack", 32'(cur_stk_own), 32'(m_own));
        chk(t, "illegal", 32'(cur_il), 32'(m_il));
        chk(t, "flags", 32'(cur_flags), 32'(m_fl));
        chk("R9", "secure", 32'(cur_secure), 32'((m_lvl == 3) || m_sec));
        chk(t, "pc_load", 32'(pc_load), 32'(e_pcl));
        if (e_pcl) chk(t, "pc_target", pc_target, e_pc);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic bit legal_ret(input int lv, input int tl, input bit sw, input bit cw,
                                     input bit c1, input bit c2);
        bit ok = 1'b1;
        if (tl > lv) ok = 1'b0;
        if (tl == lv && sw != cw) ok = 1'b0;
        if (tl < lv && sw && !cw) ok = 1'b0;
        case (tl)
            0:       if (sw && !c1) ok = 1'b0;
            1:       if (sw != c1) ok = 1'b0;
            2:       if (sw != c2) ok = 1'b0;
            default: if (!sw) ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [AW-1:0] base_of(input int l);
        case (l)
            1:       return vec_base1;
            2:       return vec_base2;
            default: return vec_base3;
        endcase
    endfunction

    // model one cycle from the inputs now applied
    task automatic model_step();
        int  t = int'(ent_lvl);
        bit  eok = ent_req && (t != 0) && (t >= m_lvl);
        e_pcl = 1'b0;
        if (eok) begin
            int grp;
            bit cw;
            tag = ret_req ? "R10" : "R2 R3 R5";
            s_lvl[t] = m_lvl; s_w64[t] = m_w64; s_own[t] = m_own;
            s_fl[t] = ent_flags; s_ra[t] = ent_ret_addr;
            if (m_lvl < t) grp = m_w64 ? 2 : 3;
            else           grp = m_own ? 1 : 0;
            e_pc = base_of(t) + AW'(grp * 32'h200) + AW'(int'(ent_type) * 32'h80);
            cw = (t == 1) ? cfg_l1_w64 : (t == 2) ? cfg_l2_w64 : 1'b1;
            m_w64 = cw | m_w64;
            m_lvl = t; m_own = 1'b1; m_il = 1'b0; m_fl = '0; e_pcl = 1'b1;
        end else if (ret_req && m_lvl != 0) begin
            int lv = m_lvl;
            e_pc = s_ra[lv]; e_pcl = 1'b1;
            if (legal_ret(lv, s_lvl[lv], s_w64[lv], m_w64, cfg_l1_w64, cfg_l2_w64)) begin
                tag = "R4 R6";
                if (lv == 3 && s_lvl[lv] < 3) m_sec = !cfg_lower_nsec;
                m_lvl = s_lvl[lv]; m_w64 = s_w64[lv]; m_own = s_own[lv];
                m_fl = s_fl[lv]; m_il = 1'b0;
            end else begin
                tag = "R7";
                m_il = 1'b1;
            end
        end else if (ret_req) begin
            tag = "R8";
        end else if (sp_sel_we) begin
            tag = "R11";
            if (m_lvl != 0) m_own = sp_sel_val;
        end else begin
            tag = "R2";
        end
    endtask

    initial begin
        rst_n = 1'b0;
        ent_req = 0; ret_req = 0; sp_sel_we = 0; sp_sel_val = 0;
        ent_type = '0; ent_lvl = '0; ent_ret_addr = '0; ent_flags = '0;
        cfg_l1_w64 = 1; cfg_l2_w64 = 1; cfg_lower_nsec = 1;
        vec_base1 = 32'h1000_0000; vec_base2 = 32'h2000_4000; vec_base3 = 32'h3000_8000;
        m_lvl = 3; m_w64 = 1; m_own = 1; m_il = 0; m_sec = 1; m_fl = '0; e_pcl = 0; e_pc = '0;
        for (int i = 0; i < 4; i++) begin
            s_lvl[i] = 0; s_w64[i] = 0; s_own[i] = 0; s_fl[i] = '0; s_ra[i] = '0;
        end
        rng = 32'h1bad_c0de;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        cmp_all("R1");
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            rng = nxt(rng);
            ent_req      = rng[0] & rng[1];
            ret_req      = rng[2] & (rng[3] | rng[4]);
            sp_sel_we    = rng[5] & rng[6];
            sp_sel_val   = rng[8];
            ent_lvl      = rng[10:9];
            ent_type     = rng[12:11];
            ent_flags    = rng[16:13];
            ent_ret_addr = {rng[31:8], 8'h00} ^ 32'h0000_5a00;
            if (k % 29 == 0) begin
                cfg_l1_w64     = rng[17];
                cfg_l2_w64     = rng[18] | rng[19];
                cfg_lower_nsec = rng[20];
            end
            model_step();
            @(posedge clk); #2;
            cmp_all(tag);
        end
        @(negedge clk);
        ent_req = 0; ret_req = 0; sp_sel_we = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule